// File: doc/BRIEF.md
# Two-stage gated clock divider

This block derives two clocks for a storage-card host from one fast input clock. A first divider stage produces a high-speed intermediate clock. A second stage, driven by the first stage's edges, produces the card clock. Each output has its own stop control, and each stop acts without runt pulses. All of this is set through a single control word. The word is written and read through a synchronous register port that has no address.

The block runs on `clk`, which is taken to be twice the nominal source rate. A stage ratio of N therefore produces a square wave whose period is 2·N cycles of `clk`. A first-stage code c gives N1 = 2^c. The second stage multiplies by a further N2 of 2 or 4. A write that asks for an illegal combination is refused and leaves a sticky error flag behind. A new ratio is applied only at the edge where the free-running card clock falls. The stop bits act at once, but only while the affected output is low.

Top module: `sdclk_gen`

## Requirements
- R1: After reset `rd_data` reads 0x0000_0300 (both stops set, first-stage code 0, second-stage code 0, no error, not running, nothing pending), and both clock outputs stay low.
- R2: The control word layout is: bit 9 stops `hs_clk_o`, bit 8 stops `card_clk_o`, bits 4:2 hold the first-stage code, bits 1:0 hold the second-stage code. An accepted write reads back in those bits. Bits 15:10 and 7:5 read as zero whatever was written to them.
- R3: With first-stage code c (0 to 4) applied and the output running, every high phase of `hs_clk_o` lasts exactly 2^c cycles of `clk`.
- R4: With second-stage code 0 (×2) or 1 (×4) applied, every high phase of `card_clk_o` lasts exactly 2^c·2 or 2^c·4 cycles, giving an overall ratio of 2 to 64.
- R5: Each stop bit silences only its own output, which then stays low.
- R6: A write whose first-stage code is above 4, or whose second-stage code is 2 or 3, is refused. The previous setting is kept, and status bit 16 is set and stays set through later legal writes until reset.
- R7: A write with first-stage code 2, 3 or 4 and bit 9 clear is refused in the same way.
- R8: Starting or stopping an output never shortens a high phase. An output rises only where its free-running divider rises and falls only where that divider falls.
- R9: Status bit 18 is set from an accepted ratio change until the change takes effect, which happens only at a falling edge of the free-running card clock. The card clock keeps its old ratio until then.
- R10: Status bit 17 is 1 exactly when both stop bits are clear.
- R11: `hs_clk_o` stays low while the applied or the requested first-stage code is 2 or more, including while a change is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock, twice the nominal source rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control fields plus status bits 16 to 18 |
| hs_clk_o | output | 1 | Gated first-stage (high-speed) clock |
| card_clk_o | output | 1 | Gated second-stage card clock |

## Verification
The bench measures the length of every high phase on both outputs and compares each one with the ratio in force at that moment. A design that cut a phase while starting or stopping an output, or that switched ratio in the middle of a card phase, would show a wrong length. It goes after the long ×64 to ×2 change and checks that the pending flag holds and the high-speed output stays quiet for the whole wait. A design that let the intermediate clock run early at /16 would show a pulse there. Illegal codes, including a large first-stage code with its stop bit clear, must leave the readback unchanged and latch an error that survives later legal writes. A design that accepted them would show altered fields or an unexpected clock.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int REG_W          = 32;
    localparam int S1_W           = 3;
    localparam int S2_W           = 2;
    localparam int NUM_LANE       = 2;
    localparam int LANE_HS        = 0;
    localparam int LANE_CARD      = 1;

    // field positions of the control word
    localparam int HS_STOP_POS    = 9;
    localparam int CARD_STOP_POS  = 8;
    localparam int S1_POS         = 2;
    localparam int S2_POS         = 0;
    // status positions
    localparam int ERR_POS        = 16;
    localparam int RUN_POS        = 17;
    localparam int PEND_POS       = 18;

    // first-stage codes at or above this value require the fast output stopped
    localparam int HS_GATE_LIMIT  = 2;

    typedef enum logic [S2_W-1:0] {
        S2_HALF    = 2'd0,
        S2_QUARTER = 2'd1
    } s2_code_e;

    typedef struct packed {
        logic [S1_W-1:0] s1;
        s2_code_e        s2;
    } sd_ratio_t;

    typedef struct packed {
        logic      hs_stop;
        logic      card_stop;
        sd_ratio_t ratio;
    } sd_cfg_t;

    localparam sd_cfg_t CFG_RESET = '{
        hs_stop:   1'b1,
        card_stop: 1'b1,
        ratio:     '{s1: '0, s2: S2_HALF}
    };

    function automatic sd_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        sd_cfg_t c;
        c.hs_stop   = w[HS_STOP_POS];
        c.card_stop = w[CARD_STOP_POS];
        c.ratio.s1  = w[S1_POS +: S1_W];
        c.ratio.s2  = s2_code_e'(w[S2_POS +: S2_W]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] word_from_cfg(input sd_cfg_t c);
        logic [REG_W-1:0] w;
        w                      = '0;
        w[HS_STOP_POS]         = c.hs_stop;
        w[CARD_STOP_POS]       = c.card_stop;
        w[S1_POS +: S1_W]      = c.ratio.s1;
        w[S2_POS +: S2_W]      = c.ratio.s2;
        return w;
    endfunction

    function automatic logic hs_code_ok(input logic [S1_W-1:0] s1);
        return int'(s1) < HS_GATE_LIMIT;
    endfunction

    function automatic logic cfg_legal(input sd_cfg_t c, input int max_s1);
        logic s1_ok;
        logic s2_ok;
        logic gate_ok;
        s1_ok   = int'(c.ratio.s1) <= max_s1;
        s2_ok   = (c.ratio.s2 == S2_HALF) || (c.ratio.s2 == S2_QUARTER);
        gate_ok = hs_code_ok(c.ratio.s1) || c.hs_stop;
        return s1_ok && s2_ok && gate_ok;
    endfunction

endpackage

// File: rtl/sdclk_cfg.sv
module sdclk_cfg
    import sdclk_pkg::*;
#(
    parameter int MAX_S1 = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             pending,
    output sd_cfg_t          cfg_q,
    output logic [REG_W-1:0] rd_data
);

    sd_cfg_t wr_cfg;
    logic    wr_ok;
    logic    err_q;

    always_comb begin
        wr_cfg = cfg_from_word(wr_data);
        wr_ok  = cfg_legal(wr_cfg, MAX_S1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            err_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_ok) cfg_q <= wr_cfg;
            else       err_q <= 1'b1;
        end
    end

    always_comb begin
        rd_data           = word_from_cfg(cfg_q);
        rd_data[ERR_POS]  = err_q;
        rd_data[RUN_POS]  = !cfg_q.hs_stop && !cfg_q.card_stop;
        rd_data[PEND_POS] = pending;
    end

    p_held_cfg_legal_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_legal(cfg_q, MAX_S1));

    p_reject_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cfg_legal(cfg_from_word(wr_data), MAX_S1)) |=> $stable(cfg_q));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
    import sdclk_pkg::*;
#(
    parameter int MAX_S1 = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  sd_ratio_t           req_ratio,
    output sd_ratio_t           act_ratio,
    output logic [NUM_LANE-1:0] raw_q,
    output logic [NUM_LANE-1:0] raw_nxt,
    output logic                pending
);

    localparam int CNT1_W = (MAX_S1 < 1) ? 1 : MAX_S1;

    logic [CNT1_W-1:0] cnt1;
    logic [CNT1_W-1:0] last1;
    logic [CNT1_W:0]   span1;
    logic [S2_W-1:0]   cnt2;
    logic [S2_W-1:0]   last2;
    logic              tick1;
    logic              wrap2;
    logic              apply;

    always_comb begin
        span1 = (CNT1_W+1)'(1) << act_ratio.s1;
        last1 = span1[CNT1_W-1:0] - CNT1_W'(1);
        last2 = (act_ratio.s2 == S2_QUARTER) ? S2_W'(3) : S2_W'(1);
        tick1 = (cnt1 == last1);
        wrap2 = tick1 && (cnt2 == last2);
        raw_nxt[LANE_HS]   = tick1 ? !raw_q[LANE_HS]   : raw_q[LANE_HS];
        raw_nxt[LANE_CARD] = wrap2 ? !raw_q[LANE_CARD] : raw_q[LANE_CARD];
        apply   = wrap2 && raw_q[LANE_CARD];
        pending = (act_ratio != req_ratio);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt1      <= '0;
            cnt2      <= '0;
            raw_q     <= '0;
            act_ratio <= CFG_RESET.ratio;
        end else begin
            cnt1  <= tick1 ? '0 : cnt1 + CNT1_W'(1);
            if (wrap2)      cnt2 <= '0;
            else if (tick1) cnt2 <= cnt2 + S2_W'(1);
            raw_q <= raw_nxt;
            if (apply) act_ratio <= req_ratio;
        end
    end

    p_apply_on_card_fall_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_ratio) |-> $fell(raw_q[LANE_CARD]));

    p_card_edge_on_hs_edge_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(raw_q[LANE_CARD]) |-> !$stable(raw_q[LANE_HS]));

endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate (
    input  logic clk,
    input  logic rst,
    input  logic raw_q,
    input  logic raw_nxt,
    input  logic run_req,
    output logic clk_o
);

    logic en_q;
    logic en_nxt;

    // the enable may only move while the free-running phase is low
    always_comb en_nxt = raw_q ? en_q : run_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            clk_o <= 1'b0;
        end else begin
            en_q  <= en_nxt;
            clk_o <= raw_nxt && en_nxt;
        end
    end

    p_out_inside_raw_r8: assert property (@(posedge clk) disable iff (rst)
        clk_o |-> raw_q);

    p_rise_with_raw_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_o) |-> $rose(raw_q));

    p_fall_with_raw_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_o) |-> $fell(raw_q));

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int MAX_S1 = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             hs_clk_o,
    output logic             card_clk_o
);

    sd_cfg_t             cfg_q;
    sd_ratio_t           act_ratio;
    logic [NUM_LANE-1:0] raw_q;
    logic [NUM_LANE-1:0] raw_nxt;
    logic [NUM_LANE-1:0] run_req;
    logic [NUM_LANE-1:0] gated;
    logic                pending;

    sdclk_cfg #(.MAX_S1(MAX_S1)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pending (pending),
        .cfg_q   (cfg_q),
        .rd_data (rd_data)
    );

    sdclk_div #(.MAX_S1(MAX_S1)) u_div (
        .clk       (clk),
        .rst       (rst),
        .req_ratio (cfg_q.ratio),
        .act_ratio (act_ratio),
        .raw_q     (raw_q),
        .raw_nxt   (raw_nxt),
        .pending   (pending)
    );

    always_comb begin
        run_req[LANE_HS]   = !cfg_q.hs_stop && hs_code_ok(act_ratio.s1)
                             && hs_code_ok(cfg_q.ratio.s1);
        run_req[LANE_CARD] = !cfg_q.card_stop;
    end

    for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
        sdclk_gate u_gate (
            .clk     (clk),
            .rst     (rst),
            .raw_q   (raw_q[g]),
            .raw_nxt (raw_nxt[g]),
            .run_req (run_req[g]),
            .clk_o   (gated[g])
        );
    end

    assign hs_clk_o   = gated[LANE_HS];
    assign card_clk_o = gated[LANE_CARD];

    p_hs_quiet_large_code_r11: assert property (@(posedge clk) disable iff (rst)
        hs_clk_o |-> hs_code_ok(act_ratio.s1));

    p_card_stop_holds_low_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.card_stop && !card_clk_o) |=> (!card_clk_o || !$stable(cfg_q)));

endmodule

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        hs_clk_o;
    logic        card_clk_o;

    int vectors = 0;
    int miscompares = 0;

    // expectations for high-phase lengths, switched when the change lands
    int exp_hs = 1, exp_card = 2;
    int nxt_hs = 1, nxt_card = 2;
    bit armed = 1'b0;
    int cur_s1 = 0, cur_s2 = 0, cur_hst = 1, cur_cst = 1;

    always #5 clk = ~clk;

    sdclk_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .hs_clk_o   (hs_clk_o),
        .card_clk_o (card_clk_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic int half_hs(input int s1);
        return 1 << s1;
    endfunction

    function automatic int half_card(input int s1, input int s2);
        return (1 << s1) * ((s2 != 0) ? 4 : 2);
    endfunction

    function automatic logic [31:0] fields(input int s1, input int s2, input int hst,
                                           input int cst);
        return (32'(hst) << 9) | (32'(cst) << 8) | (32'(s1) << 2) | 32'(s2);
    endfunction

    // run-length monitor: every completed high phase must be exact
    int  hs_run = 0, card_run = 0;
    logic hs_prev = 1'b0, card_prev = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            hs_run = 0; card_run = 0; hs_prev = 1'b0; card_prev = 1'b0;
        end else begin
            if (hs_clk_o) hs_run++;
            else if (hs_prev) begin
                check(hs_run == exp_hs, "R3,R8 hs high phase", 32'(hs_run), 32'(exp_hs));
                hs_run = 0;
            end
            if (card_clk_o) card_run++;
            else if (card_prev) begin
                check(card_run == exp_card, "R4,R8 card high phase", 32'(card_run),
                      32'(exp_card));
                card_run = 0;
            end
            hs_prev   = hs_clk_o;
            card_prev = card_clk_o;
            if (armed && !rd_data[18]) begin
                exp_hs = nxt_hs; exp_card = nxt_card; armed = 1'b0;
            end
        end
    end

    task automatic write_reg(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_apply();
        int n = 0;
        while (rd_data[18] && n < 600) begin
            @(negedge clk); n++;
        end
        check(!rd_data[18], "R9 pending clears", rd_data, 32'h0);
    endtask

    task automatic activity(input int hs_on, input int card_on);
        int win = 6 * half_card(cur_s1, cur_s2) + 8;
        int hs_rise = 0, card_rise = 0, hs_high = 0, card_high = 0;
        logic hp = hs_clk_o, cp = card_clk_o;
        repeat (2 * half_card(cur_s1, cur_s2) + 4) @(negedge clk);
        hp = hs_clk_o; cp = card_clk_o;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (hs_clk_o && !hp) hs_rise++;
            if (card_clk_o && !cp) card_rise++;
            if (hs_clk_o) hs_high++;
            if (card_clk_o) card_high++;
            hp = hs_clk_o; cp = card_clk_o;
        end
        if (hs_on != 0) check(hs_rise >= 2, "R3 hs running", 32'(hs_rise), 32'd2);
        else check(hs_high == 0, "R5,R11 hs stopped low", 32'(hs_high), 32'd0);
        if (card_on != 0) check(card_rise >= 2, "R4 card running", 32'(card_rise), 32'd2);
        else check(card_high == 0, "R5 card stopped low", 32'(card_high), 32'd0);
    endtask

    task automatic do_config(input int s1, input int s2, input int hst, input int cst,
                             input logic [31:0] junk);
        logic [31:0] f = fields(s1, s2, hst, cst);
        write_reg((junk & ~32'h0000_031F) | f);
        check((rd_data & 32'h0000_FFFF) == f, "R2 readback fields", rd_data & 32'hFFFF, f);
        nxt_hs = half_hs(s1); nxt_card = half_card(s1, s2); armed = 1'b1;
        cur_s1 = s1; cur_s2 = s2; cur_hst = hst; cur_cst = cst;
        wait_apply();
        check(rd_data[17] == ((hst == 0) && (cst == 0)), "R10 run status",
              32'(rd_data[17]), 32'((hst == 0) && (cst == 0)));
    endtask

    function automatic int hs_expected();
        return ((cur_hst == 0) && (cur_s1 < 2)) ? 1 : 0;
    endfunction

    initial begin
        #1_500_000;
        miscompares++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] saved;
        int          bad;
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data == 32'h0000_0300, "R1 reset readback", rd_data, 32'h300);
        cur_s1 = 0; cur_s2 = 0; cur_hst = 1; cur_cst = 1;
        activity(0, 0);

        // directed: fastest setting, both running
        do_config(0, 0, 0, 0, 32'hFFFF_FFFF);
        activity(1, 1);
        // directed: slowest setting
        do_config(4, 1, 1, 0, 32'h0);
        activity(0, 1);

        // R9 / R11: slow to fast change, fast output quiet while pending
        write_reg(fields(0, 0, 0, 0));
        check(rd_data[18] == 1'b1, "R9 pending after ratio write", 32'(rd_data[18]), 32'd1);
        nxt_hs = half_hs(0); nxt_card = half_card(0, 0); armed = 1'b1;
        bad = 0;
        for (int n = 0; n < 600 && rd_data[18]; n++) begin
            if (hs_clk_o) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R11 hs quiet while pending", 32'(bad), 32'd0);
        cur_s1 = 0; cur_s2 = 0; cur_hst = 0; cur_cst = 0;
        wait_apply();
        activity(1, 1);

        // R6 / R7: illegal writes refused
        saved = rd_data & 32'h3FF;
        check(rd_data[16] == 1'b0, "R6 no error before illegal write", 32'(rd_data[16]), 32'd0);
        write_reg(32'h0000_0314);
        check((rd_data & 32'h3FF) == saved, "R6 first code 5 refused", rd_data & 32'h3FF, saved);
        check(rd_data[16] == 1'b1, "R6 error latched", 32'(rd_data[16]), 32'd1);
        write_reg(32'h0000_0302);
        check((rd_data & 32'h3FF) == saved, "R6 second code 2 refused", rd_data & 32'h3FF, saved);
        write_reg(32'h0000_031F);
        check((rd_data & 32'h3FF) == saved, "R6 codes 7 and 3 refused", rd_data & 32'h3FF, saved);
        write_reg(32'h0000_010C);
        check((rd_data & 32'h3FF) == saved, "R7 code 3 without fast stop refused",
              rd_data & 32'h3FF, saved);
        activity(1, 1);
        do_config(2, 0, 1, 0, 32'h0);
        check(rd_data[16] == 1'b1, "R6 error sticky after legal write", 32'(rd_data[16]), 32'd1);
        activity(0, 1);

        // R8: stop bits toggled while both run
        do_config(1, 1, 0, 0, 32'h0);
        for (int k = 0; k < 12; k++) begin
            cur_hst = int'($urandom % 2);
            cur_cst = int'($urandom % 2);
            write_reg(fields(1, 1, cur_hst, cur_cst));
            repeat (int'($urandom % 20)) @(negedge clk);
        end
        do_config(1, 1, 0, 0, 32'h0);
        activity(1, 1);

        // random legal settings
        for (int k = 0; k < 20; k++) begin
            int s1 = int'($urandom % 5);
            int s2 = int'($urandom % 2);
            int cs = int'($urandom % 2);
            int hs = (s1 >= 2) ? 1 : int'($urandom % 2);
            do_config(s1, s2, hs, cs, $urandom);
            activity(hs_expected(), (cs == 0) ? 1 : 0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule